// File: doc/BRIEF.md
# Decode-Stage Branch Operand Bypass and Hazard Stall Unit

This block is the hazard logic that sits beside the equality comparator in the decode stage of a five-stage in-order pipeline. Conditional branches are resolved there. An older instruction may not have written its result to the register file yet. For each of the two branch source registers, the block decides whether the comparator reads the register file, the result held in the EX/MEM pipeline register, or the write-back value held in the MEM/WB pipeline register. It then compares the two chosen operands and produces the taken decision.

Some values cannot be bypassed yet, so the branch has to wait in decode:

- an ALU result that is still being computed in EX;
- a load that is still in EX;
- a load that is still in MEM.

In each of these cases the block raises a stall. The stall holds the PC and the IF/ID register and injects a bubble into ID/EX. While it is stalled the branch is not resolved.

On a taken branch the block asks for the one instruction fetched behind the branch to be flushed, so the PC can be loaded with the target. All outputs are combinational functions of the present inputs. They act at the next clock edge of the surrounding pipeline.

Top module: `br_resolve`

## Requirements
- R1: While `branch_id` is low, both selects are 0, and `stall_id`, `fe_hold`, `br_taken` and `if_flush` are all low, whatever the pipeline-register inputs hold.
- R2: A source operand's select is 1 (EX/MEM result) when EX/MEM writes a nonzero register equal to that source and is not a load.
- R3: A source operand's select is 2 (MEM/WB value) when MEM/WB writes a nonzero register equal to that source and R2 does not apply. EX/MEM wins when both match. Select 0 means the register file.
- R4: `stall_id` is high when ID/EX writes a nonzero register equal to either branch source, whether that instruction is a load or an ALU operation.
- R5: `stall_id` is high when EX/MEM holds a load that writes a nonzero register equal to either branch source. A load in EX/MEM is never chosen by select 1.
- R6: Register 0 as a branch source or as a destination never produces a nonzero select or a stall.
- R7: While `stall_id` is high, `fe_hold` is high and `br_taken` and `if_flush` are low, even if the operands compare equal.
- R8: When a branch is active and not stalled, `br_taken` is high exactly when the two selected operands are equal. `if_flush` equals `br_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| branch_id | input | 1 | Decode-stage instruction is a branch-on-equal |
| rs_id | input | REG_AW | First branch source register number |
| rt_id | input | REG_AW | Second branch source register number |
| rs_val | input | DATA_W | Register file value for the first source |
| rt_val | input | DATA_W | Register file value for the second source |
| idex_we | input | 1 | ID/EX instruction writes a register |
| idex_rd | input | REG_AW | ID/EX destination register |
| exmem_we | input | 1 | EX/MEM instruction writes a register |
| exmem_load | input | 1 | EX/MEM instruction is a load |
| exmem_rd | input | REG_AW | EX/MEM destination register |
| exmem_val | input | DATA_W | EX/MEM ALU result |
| memwb_we | input | 1 | MEM/WB instruction writes a register |
| memwb_rd | input | REG_AW | MEM/WB destination register |
| memwb_val | input | DATA_W | MEM/WB write-back value |
| fwd_a | output | 2 | First operand source: 0 register file, 1 EX/MEM, 2 MEM/WB |
| fwd_b | output | 2 | Second operand source, same encoding |
| br_taken | output | 1 | Branch resolved taken; load PC with target |
| stall_id | output | 1 | Bubble into ID/EX; branch held in decode |
| fe_hold | output | 1 | Hold PC and IF/ID this cycle |
| if_flush | output | 1 | Squash the instruction in IF |

## Verification
Every result of this block is due in the same cycle as the stimulus, because no register lies between the inputs and the outputs. The pipeline acts on these results at the following clock edge. The bench therefore drives each new input set just after a rising edge and compares all six outputs at the next falling edge, when they have settled. The same timing is used for directed cases on each hazard pattern and for a long run of random register numbers drawn from a small range, so that matches are frequent.

// File: rtl/br_hz_pkg.sv
package br_hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } src_sel_e;
endpackage

// File: rtl/br_src_pick.sv
module br_src_pick
  import br_hz_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 32,
  parameter bit WB_BYPASS = 1'b1
) (
  input  logic              active,
  input  logic [REG_AW-1:0] src_reg,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              exmem_we,
  input  logic              exmem_load,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic [DATA_W-1:0] exmem_val,
  input  logic              memwb_we,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic [DATA_W-1:0] memwb_val,
  output src_sel_e          sel,
  output logic [DATA_W-1:0] opnd
);
  logic src_nz;
  logic hit_em;
  logic hit_wb;

  assign src_nz = (src_reg != '0);
  assign hit_em = active && src_nz && exmem_we && !exmem_load && (exmem_rd == src_reg);

  generate
    if (WB_BYPASS) begin : g_wb_bypass
      assign hit_wb = active && src_nz && memwb_we && (memwb_rd == src_reg);
    end else begin : g_wb_regfile
      assign hit_wb = 1'b0;
    end
  endgenerate

  always_comb begin
    if (hit_em)      sel = SRC_EXMEM;
    else if (hit_wb) sel = SRC_MEMWB;
    else             sel = SRC_RF;
  end

  always_comb begin
    unique case (sel)
      SRC_EXMEM: opnd = exmem_val;
      SRC_MEMWB: opnd = memwb_val;
      default:   opnd = rf_val;
    endcase
  end

  always_comb begin
    a_r5_no_load_bypass: assert (!(exmem_load && sel == SRC_EXMEM));
    a_r6_zero_no_bypass: assert (!(src_reg == '0 && sel != SRC_RF));
  end
endmodule

// File: rtl/br_stall_chk.sv
module br_stall_chk #(
  parameter int REG_AW = 5
) (
  input  logic              active,
  input  logic [REG_AW-1:0] rs_id,
  input  logic [REG_AW-1:0] rt_id,
  input  logic              idex_we,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              exmem_we,
  input  logic              exmem_load,
  input  logic [REG_AW-1:0] exmem_rd,
  output logic              stall
);
  logic ex_dep;
  logic ld_dep;

  always_comb begin
    ex_dep = idex_we && (idex_rd != '0) &&
             ((idex_rd == rs_id) || (idex_rd == rt_id));
    ld_dep = exmem_we && exmem_load && (exmem_rd != '0) &&
             ((exmem_rd == rs_id) || (exmem_rd == rt_id));
    stall  = active && (ex_dep || ld_dep);
  end

  always_comb begin
    a_r1_idle_no_stall: assert (active || !stall);
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_hz_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 32,
  parameter bit WB_BYPASS = 1'b1
) (
  input  logic              branch_id,
  input  logic [REG_AW-1:0] rs_id,
  input  logic [REG_AW-1:0] rt_id,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic              idex_we,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              exmem_we,
  input  logic              exmem_load,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic [DATA_W-1:0] exmem_val,
  input  logic              memwb_we,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic [DATA_W-1:0] memwb_val,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              br_taken,
  output logic              stall_id,
  output logic              fe_hold,
  output logic              if_flush
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0][REG_AW-1:0] src_reg;
  logic [N_SRC-1:0][DATA_W-1:0] rf_val;
  logic [N_SRC-1:0][DATA_W-1:0] opnd;
  src_sel_e                     sel [N_SRC];
  logic                         ops_eq;

  assign src_reg[0] = rs_id;
  assign src_reg[1] = rt_id;
  assign rf_val[0]  = rs_val;
  assign rf_val[1]  = rt_val;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    br_src_pick #(
      .REG_AW   (REG_AW),
      .DATA_W   (DATA_W),
      .WB_BYPASS(WB_BYPASS)
    ) u_pick (
      .active    (branch_id),
      .src_reg   (src_reg[i]),
      .rf_val    (rf_val[i]),
      .exmem_we  (exmem_we),
      .exmem_load(exmem_load),
      .exmem_rd  (exmem_rd),
      .exmem_val (exmem_val),
      .memwb_we  (memwb_we),
      .memwb_rd  (memwb_rd),
      .memwb_val (memwb_val),
      .sel       (sel[i]),
      .opnd      (opnd[i])
    );
  end

  br_stall_chk #(.REG_AW(REG_AW)) u_stall (
    .active    (branch_id),
    .rs_id     (rs_id),
    .rt_id     (rt_id),
    .idex_we   (idex_we),
    .idex_rd   (idex_rd),
    .exmem_we  (exmem_we),
    .exmem_load(exmem_load),
    .exmem_rd  (exmem_rd),
    .stall     (stall_id)
  );

  always_comb begin
    fwd_a    = sel[0];
    fwd_b    = sel[1];
    ops_eq   = (opnd[0] == opnd[1]);
    br_taken = branch_id && !stall_id && ops_eq;
    fe_hold  = stall_id;
    if_flush = br_taken;
  end

  always_comb begin
    a_r7_stall_blocks_redirect: assert (!(stall_id && (br_taken || if_flush)));
    a_r7_stall_holds_front:     assert (!stall_id || fe_hold);
    a_r8_flush_with_taken:      assert (if_flush == br_taken);
    a_r1_idle_quiet:            assert (branch_id || (fwd_a == 2'd0 && fwd_b == 2'd0 && !br_taken));
  end
endmodule

// File: tb/br_resolve_bench.sv
module br_resolve_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          br, ie, ee, el, we_;
  logic [AW-1:0] rs, rt, ird, erd, wrd;
  logic [DW-1:0] rsv, rtv, ev, wv;
  logic [1:0]    fa, fb;
  logic          tk, st, hd, fl;

  int checks = 0;
  int errors = 0;

  br_resolve #(.REG_AW(AW), .DATA_W(DW)) u_br_resolve (
    .branch_id(br), .rs_id(rs), .rt_id(rt), .rs_val(rsv), .rt_val(rtv),
    .idex_we(ie), .idex_rd(ird),
    .exmem_we(ee), .exmem_load(el), .exmem_rd(erd), .exmem_val(ev),
    .memwb_we(we_), .memwb_rd(wrd), .memwb_val(wv),
    .fwd_a(fa), .fwd_b(fb), .br_taken(tk), .stall_id(st),
    .fe_hold(hd), .if_flush(fl)
  );

  function automatic int pick(int r);
    if (!br || r == 0) return 0;
    if (ee && !el && int'(erd) == r) return 1;
    if (we_ && int'(wrd) == r) return 2;
    return 0;
  endfunction

  function automatic logic [DW-1:0] pval(int s, logic [DW-1:0] rf);
    if (s == 1) return ev;
    if (s == 2) return wv;
    return rf;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check(string tag);
    int  ea, eb;
    bit  es, et;
    ea = pick(int'(rs));
    eb = pick(int'(rt));
    es = br && ((ie && ird != 0 && (ird == rs || ird == rt)) ||
                (ee && el && erd != 0 && (erd == rs || erd == rt)));
    et = br && !es && (pval(ea, rsv) == pval(eb, rtv));
    cmp(tag, "fwd_a", int'(fa), ea);
    cmp(tag, "fwd_b", int'(fb), eb);
    cmp(tag, "stall_id", int'(st), int'(es));
    cmp(tag, "fe_hold", int'(hd), int'(es));
    cmp(tag, "br_taken", int'(tk), int'(et));
    cmp(tag, "if_flush", int'(fl), int'(et));
  endtask

  task automatic clr();
    br = 0; ie = 0; ee = 0; el = 0; we_ = 0;
    rs = 0; rt = 0; ird = 0; erd = 0; wrd = 0;
    rsv = 0; rtv = 0; ev = 0; wv = 0;
  endtask

  task automatic step(string tag);
    @(negedge clk);
    check(tag);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr();
    @(posedge clk); #1;
    step("R1 reset idle");
    // R1: hazards present but no branch
    ie = 1; ird = 3; ee = 1; erd = 4; el = 1; we_ = 1; wrd = 5; rs = 3; rt = 4;
    step("R1 inactive");
    // R2: EX/MEM bypass of rs, operands equal -> taken
    clr(); br = 1; rs = 3; rt = 6; ee = 1; erd = 3; ev = 32'h55; rsv = 9; rtv = 32'h55;
    step("R2 exmem fwd");
    // R3: MEM/WB bypass of rt
    clr(); br = 1; rs = 2; rt = 4; we_ = 1; wrd = 4; wv = 7; rsv = 7; rtv = 1;
    step("R3 memwb fwd");
    // R3: both stages match rs, EX/MEM wins
    clr(); br = 1; rs = 5; rt = 6; ee = 1; erd = 5; ev = 11; we_ = 1; wrd = 5; wv = 22; rtv = 11;
    step("R3 priority");
    // R4: ALU result in EX
    clr(); br = 1; rs = 1; rt = 7; ie = 1; ird = 7;
    step("R4 alu in ex");
    // R4: load in EX
    clr(); br = 1; rs = 8; rt = 2; ie = 1; ird = 8; el = 0;
    step("R4 load in ex");
    // R5: load in MEM
    clr(); br = 1; rs = 9; rt = 3; ee = 1; el = 1; erd = 9; ev = 4;
    step("R5 load in mem");
    // R6: register 0 everywhere
    clr(); br = 1; rs = 0; rt = 0; ie = 1; ird = 0; ee = 1; erd = 0; we_ = 1; wrd = 0; ev = 3; wv = 4;
    step("R6 zero reg");
    // R7: stall with equal operands must not take
    clr(); br = 1; rs = 2; rt = 3; rsv = 5; rtv = 5; ie = 1; ird = 2;
    step("R7 stall no taken");
    // R8: unequal -> not taken; equal -> taken
    clr(); br = 1; rs = 4; rt = 5; rsv = 1; rtv = 2;
    step("R8 not taken");
    rtv = 1;
    step("R8 taken");
    for (int i = 0; i < 3000; i++) begin
      br  = $urandom_range(0, 3) != 0;
      rs  = AW'($urandom_range(0, 3)); rt  = AW'($urandom_range(0, 3));
      ird = AW'($urandom_range(0, 3)); erd = AW'($urandom_range(0, 3));
      wrd = AW'($urandom_range(0, 3));
      ie = 1'($urandom); ee = 1'($urandom); el = 1'($urandom); we_ = 1'($urandom);
      rsv = DW'($urandom_range(0, 2)); rtv = DW'($urandom_range(0, 2));
      ev  = DW'($urandom_range(0, 2)); wv  = DW'($urandom_range(0, 2));
      step("R8 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule